// File: doc/BRIEF.md
# Gain-Shifted CIC Decimator

This block reduces the sample rate of one real, signed sample stream. Each accepted sample, marked by a valid strobe, first passes a barrel shifter that multiplies it by a power of two. It then runs through a fifth-order cascaded integrator-comb filter. Five integrators run at the input rate and five single-delay combs run at the decimated rate, so one filtered word is produced for every R accepted samples.

The shift amount is the sum of a 4-bit programmed value and a 3-bit value presented on pins alongside each sample. The sum is clamped at 15. The pin value is registered in the same stage as the sample it belongs to, so a new gain applies exactly to the sample that arrives with it. This lets a front end undo the CIC gain growth for a given decimation factor in coarse 6 dB steps.

A bypass control skips the filter. Every shifted sample is then sent to the output, left-aligned in the wide output word. All arithmetic wraps modulo the accumulator width, which is the input width plus 15 plus 30 bits.

Top module: `cic_gain_decim`

## Requirements
- R1: With bypass off and a constant input x, the output settles to x·2^s·R^5, where R is the effective decimation factor and s is the applied shift. The arithmetic is two's complement, modulo 2^(IN_W+45).
- R2: Each accepted sample is multiplied by 2^s, where s = shift_gain + gain_pin when that sum is 15 or less.
- R3: When shift_gain + gain_pin exceeds 15, the applied shift is 15.
- R4: The gain_pin value presented in the same cycle as a sample sets the shift for that sample only. Changing it from one sample to the next gives each sample its own gain.
- R5: With bypass off, out_valid pulses once for every R accepted samples. Cycles where in_valid is low neither advance the count nor produce an output.
- R6: A decim value of 0, 1, 2 or 3 behaves as R = 4. Values from 4 to 63 give R = decim.
- R7: With bypass on, every accepted sample produces one output. The shifted sample (IN_W+15 bits, signed) sits in the most significant bits of out_data, and the low 30 bits are zero.
- R8: Each output appears two rising clock edges after the edge that accepts the sample completing it, in both modes.
- R9: Reset (rst_n low, asynchronous) clears out_valid, all integrator and comb state and the decimation count. The first output after reset equals that of a freshly started filter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| shift_gain | input | 4 | Programmed part of the shift amount |
| decim | input | 6 | Decimation factor (values below 4 act as 4) |
| bypass | input | 1 | 1 = skip the CIC and output shifted samples |
| in_valid | input | 1 | Sample strobe |
| in_data | input | IN_W (12) | Signed input sample |
| gain_pin | input | 3 | Per-sample part of the shift amount |
| out_valid | output | 1 | Output word strobe |
| out_data | output | IN_W+45 (57) | Signed filtered word, or shifted sample in the MSBs during bypass |

## Verification
Every result of this block, whether a decimated word or a bypassed sample, is due exactly two rising edges after the edge that takes in the sample completing it. The bench drives inputs on the falling edge and keeps a two-entry queue of expected (valid, data) pairs. On each falling edge it compares the outputs with the entry queued two falling edges earlier, so that cycles without a valid output are checked too. For settled constant inputs, a closed-form gain is also compared with the last output word.

// File: rtl/cic_gain_pkg.sv
package cic_gain_pkg;
    localparam int CIC_ORDER = 5;
    localparam int DEC_W     = 6;
    localparam int GREG_W    = 4;
    localparam int GPIN_W    = 3;
    localparam int SHIFT_MAX = 15;
    localparam int SHIFT_W   = 4;
    localparam int SUM_W     = GREG_W + 1;
    localparam int MIN_RATIO = 4;

    // effective decimation ratio: small settings are raised to the minimum
    function automatic logic [DEC_W-1:0] eff_ratio(input logic [DEC_W-1:0] d);
        return (d < DEC_W'(MIN_RATIO)) ? DEC_W'(MIN_RATIO) : d;
    endfunction

    // saturating sum of programmed and per-sample shift
    function automatic logic [SHIFT_W-1:0] sat_shift(input logic [GREG_W-1:0] r,
                                                     input logic [GPIN_W-1:0] p);
        logic [SUM_W-1:0] s;
        s = {1'b0, r} + SUM_W'(p);
        return (s > SUM_W'(SHIFT_MAX)) ? SHIFT_W'(SHIFT_MAX) : s[SHIFT_W-1:0];
    endfunction
endpackage

// File: rtl/cic_pre_shift.sv
module cic_pre_shift
    import cic_gain_pkg::*;
#(
    parameter int IN_W = 12,
    parameter int SH_W = IN_W + SHIFT_MAX
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic signed [IN_W-1:0]  in_data,
    input  logic [GPIN_W-1:0]       gain_pin,
    input  logic [GREG_W-1:0]       shift_gain,
    output logic                    sh_valid,
    output logic [SH_W-1:0]         sh_data
);
    typedef struct packed {
        logic            valid;
        logic [SH_W-1:0] data;
    } sh_state_t;

    sh_state_t state_d, state_q;
    logic [SHIFT_W-1:0] amt;
    logic [SH_W-1:0]    stg [SHIFT_W+1];

    assign amt    = sat_shift(shift_gain, gain_pin);
    assign stg[0] = {{(SH_W-IN_W){in_data[IN_W-1]}}, in_data};

    // logarithmic barrel shifter, one layer per bit of the amount
    for (genvar g = 0; g < SHIFT_W; g++) begin : g_layer
        assign stg[g+1] = amt[g] ? (stg[g] << (2**g)) : stg[g];
    end

    always_comb begin
        state_d       = state_q;
        state_d.valid = in_valid;
        if (in_valid) begin
            state_d.data = stg[SHIFT_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign sh_valid = state_q.valid;
    assign sh_data  = state_q.data;
endmodule

// File: rtl/cic_integ_chain.sv
module cic_integ_chain
    import cic_gain_pkg::*;
#(
    parameter int SH_W  = 27,
    parameter int ACC_W = SH_W + CIC_ORDER * DEC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sh_valid,
    input  logic [SH_W-1:0]   sh_data,
    input  logic              bypass,
    input  logic [DEC_W-1:0]  decim,
    output logic              fire,
    output logic [ACC_W-1:0]  last_sum
);
    typedef struct packed {
        logic [CIC_ORDER-1:0][ACC_W-1:0] acc;
        logic [DEC_W-1:0]                cnt;
    } integ_state_t;

    integ_state_t     state_d, state_q;
    logic [ACC_W-1:0] feed;
    logic [DEC_W-1:0] ratio;
    logic             step;

    assign ratio = eff_ratio(decim);
    assign step  = sh_valid && !bypass;

    always_comb begin
        state_d = state_q;
        fire    = 1'b0;
        feed    = {{(ACC_W-SH_W){sh_data[SH_W-1]}}, sh_data};
        if (step) begin
            for (int k = 0; k < CIC_ORDER; k++) begin
                state_d.acc[k] = state_q.acc[k] + feed;
                feed           = state_d.acc[k];
            end
            if (state_q.cnt >= ratio - DEC_W'(1)) begin
                fire        = 1'b1;
                state_d.cnt = '0;
            end else begin
                state_d.cnt = state_q.cnt + DEC_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign last_sum = state_d.acc[CIC_ORDER-1];
endmodule

// File: rtl/cic_comb_chain.sv
module cic_comb_chain
    import cic_gain_pkg::*;
#(
    parameter int SH_W  = 27,
    parameter int ACC_W = SH_W + CIC_ORDER * DEC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic [ACC_W-1:0]  int_sum,
    input  logic              byp_valid,
    input  logic [SH_W-1:0]   sh_data,
    output logic              out_valid,
    output logic [ACC_W-1:0]  out_data
);
    typedef struct packed {
        logic [CIC_ORDER-1:0][ACC_W-1:0] dly;
        logic                            valid;
        logic [ACC_W-1:0]                data;
    } comb_state_t;

    comb_state_t      state_d, state_q;
    logic [ACC_W-1:0] run;

    always_comb begin
        state_d       = state_q;
        state_d.valid = 1'b0;
        run           = int_sum;
        if (fire) begin
            for (int k = 0; k < CIC_ORDER; k++) begin
                state_d.dly[k] = run;
                run            = run - state_q.dly[k];
            end
            state_d.valid = 1'b1;
            state_d.data  = run;
        end else if (byp_valid) begin
            state_d.valid = 1'b1;
            state_d.data  = {sh_data, {(ACC_W-SH_W){1'b0}}};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign out_valid = state_q.valid;
    assign out_data  = state_q.data;
endmodule

// File: rtl/cic_gain_decim.sv
module cic_gain_decim
    import cic_gain_pkg::*;
#(
    parameter  int IN_W  = 12,
    localparam int SH_W  = IN_W + SHIFT_MAX,
    localparam int ACC_W = SH_W + CIC_ORDER * DEC_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [GREG_W-1:0]      shift_gain,
    input  logic [DEC_W-1:0]       decim,
    input  logic                   bypass,
    input  logic                   in_valid,
    input  logic signed [IN_W-1:0] in_data,
    input  logic [GPIN_W-1:0]      gain_pin,
    output logic                   out_valid,
    output logic [ACC_W-1:0]       out_data
);
    logic             sh_valid;
    logic [SH_W-1:0]  sh_data;
    logic             fire;
    logic [ACC_W-1:0] last_sum;
    logic             byp_valid;

    cic_pre_shift #(.IN_W(IN_W), .SH_W(SH_W)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .gain_pin   (gain_pin),
        .shift_gain (shift_gain),
        .sh_valid   (sh_valid),
        .sh_data    (sh_data)
    );

    cic_integ_chain #(.SH_W(SH_W), .ACC_W(ACC_W)) u_integ (
        .clk      (clk),
        .rst_n    (rst_n),
        .sh_valid (sh_valid),
        .sh_data  (sh_data),
        .bypass   (bypass),
        .decim    (decim),
        .fire     (fire),
        .last_sum (last_sum)
    );

    assign byp_valid = sh_valid && bypass;

    cic_comb_chain #(.SH_W(SH_W), .ACC_W(ACC_W)) u_comb (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire      (fire),
        .int_sum   (last_sum),
        .byp_valid (byp_valid),
        .sh_data   (sh_data),
        .out_valid (out_valid),
        .out_data  (out_data)
    );
endmodule

// File: rtl/cic_gain_decim_chk.sv
module cic_gain_decim_chk
    import cic_gain_pkg::*;
#(
    parameter int LO_W = 30
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             bypass,
    input logic [DEC_W-1:0] decim,
    input logic             out_valid,
    input logic [LO_W-1:0]  out_lo
);
    logic           v1_q, v2_q, byp_q;
    logic [DEC_W:0] acc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v1_q  <= 1'b0;
            v2_q  <= 1'b0;
            byp_q <= 1'b0;
            acc_q <= '0;
        end else begin
            v1_q  <= in_valid;
            v2_q  <= v1_q;
            byp_q <= bypass;
            if (byp_q)     acc_q <= '0;
            else if (v2_q) acc_q <= out_valid ? '0 : acc_q + 1'b1;
        end
    end

    AST_OUT_NEEDS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> v2_q); // R8

    AST_BYPASS_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (bypass && byp_q) |-> (out_valid == v2_q)); // R7

    AST_BYPASS_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && byp_q) |-> (out_lo == '0)); // R7

    AST_DECIM_RATE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !byp_q) |-> (acc_q + 1'b1 == {1'b0, eff_ratio(decim)})); // R5

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!v1_q && !v2_q) |-> !out_valid); // R9
endmodule

bind cic_gain_decim cic_gain_decim_chk #(.LO_W(ACC_W - SH_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .bypass    (bypass),
    .decim     (decim),
    .out_valid (out_valid),
    .out_lo    (out_data[ACC_W-SH_W-1:0])
);

// File: tb/cic_gain_decim_tb.sv
module cic_gain_decim_tb;
    localparam int CLK_PERIOD = 10;
    localparam int IN_W  = 12;
    localparam int SH_W  = IN_W + 15;
    localparam int ACC_W = SH_W + 30;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic [3:0]             shift_gain = '0;
    logic [5:0]             decim = 6'd4;
    logic                   bypass = 1'b0;
    logic                   in_valid = 1'b0;
    logic signed [IN_W-1:0] in_data = '0;
    logic [2:0]             gain_pin = '0;
    logic                   out_valid;
    logic [ACC_W-1:0]       out_data;

    cic_gain_decim #(.IN_W(IN_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .shift_gain(shift_gain), .decim(decim),
        .bypass(bypass), .in_valid(in_valid), .in_data(in_data),
        .gain_pin(gain_pin), .out_valid(out_valid), .out_data(out_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct packed {
        logic        byp;
        logic [5:0]  dec;
        logic [3:0]  sg;
        logic [2:0]  gp;
        logic [11:0] x;
        logic [9:0]  n;
        logic        gap;
        logic        vary;
        logic        dc;
        logic [3:0]  req;
    } scen_t;

    localparam int NSCEN = 8;
    localparam scen_t SCN [NSCEN] = '{
        '{1'b0, 6'd8,  4'd2,  3'd1, 12'd100,  10'd64,  1'b0, 1'b0, 1'b1, 4'd1},
        '{1'b0, 6'd63, 4'd15, 3'd7, 12'h800,  10'd504, 1'b0, 1'b0, 1'b1, 4'd3},
        '{1'b0, 6'd2,  4'd0,  3'd0, 12'd5,    10'd40,  1'b1, 1'b0, 1'b1, 4'd6},
        '{1'b0, 6'd0,  4'd1,  3'd2, 12'hFF9,  10'd40,  1'b0, 1'b0, 1'b1, 4'd6},
        '{1'b0, 6'd5,  4'd3,  3'd0, 12'd0,    10'd60,  1'b1, 1'b1, 1'b0, 4'd5},
        '{1'b1, 6'd0,  4'd4,  3'd0, 12'd0,    10'd20,  1'b1, 1'b1, 1'b0, 4'd4},
        '{1'b1, 6'd0,  4'd12, 3'd6, 12'd1,    10'd6,   1'b0, 1'b0, 1'b0, 4'd3},
        '{1'b0, 6'd16, 4'd0,  3'd3, 12'd3,    10'd128, 1'b0, 1'b0, 1'b1, 4'd2}
    };

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    logic [ACC_W-1:0] mi [5];
    logic [ACC_W-1:0] md [5];
    int               mcnt;
    bit               ev [2];
    logic [ACC_W-1:0] ed [2];
    logic [ACC_W-1:0] last_out;

    function automatic string tag_of(input int r);
        case (r)
            1: return "R1";
            2: return "R2";
            3: return "R3";
            4: return "R4";
            5: return "R5";
            6: return "R6";
            7: return "R7";
            8: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
        end
    endtask

    task automatic model_clear();
        for (int k = 0; k < 5; k++) begin
            mi[k] = '0;
            md[k] = '0;
        end
        mcnt = 0;
        ev[0] = 1'b0; ev[1] = 1'b0;
        ed[0] = '0;   ed[1] = '0;
    endtask

    task automatic do_reset(input bit byp, input logic [5:0] dec, input logic [3:0] sg);
        @(negedge clk);
        rst_n    = 1'b0;
        in_valid = 1'b0;
        bypass   = byp;
        decim    = dec;
        shift_gain = sg;
        repeat (2) @(negedge clk);
        check(out_valid == 1'b0, "R9", "out_valid in reset", longint'(out_valid), 0);
        rst_n = 1'b1;
        model_clear();
    endtask

    // one cycle: check output due from two cycles back, then drive a new input
    task automatic step(input bit v, input logic signed [IN_W-1:0] x,
                        input logic [2:0] gp, input string tag);
        int     s, r;
        longint sv;
        logic [ACC_W-1:0] c, t;
        @(negedge clk);
        check(out_valid == ev[1], tag, "out_valid", longint'(out_valid), longint'(ev[1]));
        if (ev[1])
            check(out_data === ed[1], tag, "out_data",
                  longint'($signed(out_data)), longint'($signed(ed[1])));
        if (out_valid) last_out = out_data;
        ev[1] = ev[0];
        ed[1] = ed[0];
        ev[0] = 1'b0;
        in_valid = v;
        in_data  = x;
        gain_pin = gp;
        if (v) begin
            s = int'(shift_gain) + int'(gp);
            if (s > 15) s = 15;
            sv = longint'(x) <<< s;
            if (bypass) begin
                ev[0] = 1'b1;
                ed[0] = {sv[SH_W-1:0], 30'b0};
            end else begin
                c = sv[ACC_W-1:0];
                for (int k = 0; k < 5; k++) begin
                    mi[k] = mi[k] + c;
                    c = mi[k];
                end
                r = (decim < 4) ? 4 : int'(decim);
                if (mcnt >= r - 1) begin
                    mcnt = 0;
                    for (int k = 0; k < 5; k++) begin
                        t = c - md[k];
                        md[k] = c;
                        c = t;
                    end
                    ev[0] = 1'b1;
                    ed[0] = c;
                end else begin
                    mcnt++;
                end
            end
        end
    endtask

    task automatic drain(input string tag);
        for (int i = 0; i < 3; i++) step(1'b0, '0, '0, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        string tg;
        // table-driven scenarios
        for (int e = 0; e < NSCEN; e++) begin
            int     r, s;
            longint dcv;
            tg = tag_of(int'(SCN[e].req));
            do_reset(SCN[e].byp, SCN[e].dec, SCN[e].sg);
            last_out = '0;
            for (int i = 0; i < int'(SCN[e].n); i++) begin
                logic signed [IN_W-1:0] xv;
                logic [2:0]             gv;
                xv = SCN[e].vary ? IN_W'((i * 37 + 5) % 200 - 100) : SCN[e].x;
                gv = SCN[e].vary ? 3'(i % 8) : SCN[e].gp;
                step(1'b1, xv, gv, tg);
                if (SCN[e].gap) step(1'b0, 12'h5A5, 3'd7, tg);
            end
            drain(tg);
            if (SCN[e].dc) begin
                r = (SCN[e].dec < 4) ? 4 : int'(SCN[e].dec);
                s = int'(SCN[e].sg) + int'(SCN[e].gp);
                if (s > 15) s = 15;
                dcv = longint'($signed(SCN[e].x)) <<< s;
                for (int k = 0; k < 5; k++) dcv = dcv * r;
                // R1: settled DC gain of the fifth-order filter
                check(longint'($signed(last_out)) == dcv, tg, "settled DC output (R1)",
                      longint'($signed(last_out)), dcv);
            end
        end

        // R8: latency of a single bypassed sample
        do_reset(1'b1, 6'd4, 4'd0);
        step(1'b1, 12'sd9, 3'd0, "R8");
        step(1'b0, '0, '0, "R8");
        step(1'b0, '0, '0, "R8");
        check(out_data == {27'sd9, 30'b0}, "R8", "bypass word", longint'($signed(out_data)),
              longint'(64'sd9 <<< 30));
        drain("R8");

        // R9: reset in the middle of a decimation window clears state
        do_reset(1'b0, 6'd4, 4'd1);
        for (int i = 0; i < 3; i++) step(1'b1, 12'sd50, 3'd0, "R9");
        do_reset(1'b0, 6'd4, 4'd1);
        for (int i = 0; i < 4; i++) step(1'b1, 12'sd1, 3'd0, "R9");
        drain("R9");
        // first output of a fresh filter with x=2: 2*C(8,5)=112
        check(longint'($signed(last_out)) == 112, "R9", "first output after reset",
              longint'($signed(last_out)), 112);

        // R2 with R5: alternating pin gain, decimation by 4
        do_reset(1'b0, 6'd4, 4'd0);
        for (int i = 0; i < 24; i++) step(1'b1, -12'sd3, 3'(i % 2), "R2");
        drain("R5");

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule